// File: doc/BRIEF.md
# Mode-Switchable Index Register Unit

This block holds one processor index register whose operating width changes at run time. A width-select input picks between a 16-bit and an 8-bit register, and an emulation-mode input forces 8-bit operation whatever the select input says. The register can be loaded, stepped up or down by exactly one, filled from the stack pointer value, or copied out towards the stack pointer. Each load, step or fill updates a negative flag and a zero flag taken at the active width.

Alongside the register, the block forms a 24-bit indexed effective address. A bank byte and a 16-bit base are joined into one 24-bit number, and the register value is added to it as an unsigned, zero-extended quantity. A carry out of the low 16 bits runs into the bank byte, so the address can cross a bank boundary. The register value after reset is undefined until the first write. The flags reset to zero.

Top module: `index_reg_unit`

## Requirements
- R1: With `widthSel`=0 and `emuMode`=0 the register is 16 bits wide. With `widthSel`=1, or with `emuMode`=1, it is 8 bits wide and `idxOut[15:8]` reads zero.
- R2: `op`=1 (load) writes `loadData`, masked to the active width. The new value is visible on `idxOut` after the next rising clock edge.
- R3: `op`=2 (step up) adds one and wraps within the active width. In 8-bit width 0x00FF becomes 0x0000. In 16-bit width 0x00FF becomes 0x0100 and 0xFFFF becomes 0x0000.
- R4: `op`=3 (step down) subtracts one and wraps within the active width. 0x0000 becomes 0x00FF in 8-bit width and 0xFFFF in 16-bit width.
- R5: Load, step up, step down and fill from stack update the flags on the same clock edge as the register. `negFlag` takes bit 7 of the result in 8-bit width and bit 15 in 16-bit width. `zeroFlag` is set when the active-width result is all zeros. Both flags reset to 0.
- R6: `op`=5 (copy to stack) raises `spWe` combinationally in the same cycle and leaves the register and both flags unchanged. `spOut` equals `idxOut` outside emulation mode. In emulation mode `spOut` is 0x01 followed by the low byte of the register.
- R7: `op`=4 (fill from stack) writes `spIn`, masked to the active width, into the register.
- R8: `effAddr` equals ({`bank`,`base`} + `idxOut` zero-extended) modulo 2^24. It is combinational, and a carry from bit 15 enters the bank byte.
- R9: `op` values 0, 6 and 7 leave the register and both flags unchanged.
- R10: Each clock edge in 8-bit width clears the stored high byte. A later return to 16-bit width therefore shows a zero high byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset of the flags |
| op | input | 3 | Operation select (0 hold, 1 load, 2 step up, 3 step down, 4 fill from stack, 5 copy to stack, 6-7 hold) |
| loadData | input | 16 | Value for the load operation |
| widthSel | input | 1 | Width select: 0 gives 16 bits, 1 gives 8 bits |
| emuMode | input | 1 | Emulation mode; forces 8-bit width |
| spIn | input | 16 | Current stack pointer value |
| bank | input | 8 | Bank byte of the address base |
| base | input | 16 | Low 16 bits of the address base |
| idxOut | output | 16 | Register value at the active width |
| negFlag | output | 1 | Negative flag |
| zeroFlag | output | 1 | Zero flag |
| spWe | output | 1 | Write strobe towards the stack pointer |
| spOut | output | 16 | Value to write into the stack pointer |
| effAddr | output | 24 | Indexed effective address |

## Verification
The bench builds the block with its default widths: a 16-bit register, an 8-bit narrow width and an 8-bit bank. With these widths both wrap points, 0xFF and 0xFFFF, can be reached with one load and one step. The carry from 0xFFFF into the bank byte, including the full 24-bit rollover, can be set up directly. An 8-bit value with its top bit set shows that the address adder zero-extends and does not sign-extend.

// File: rtl/idx_pkg.sv
package idx_pkg;

  localparam logic [2:0] OP_NOP     = 3'd0;
  localparam logic [2:0] OP_LOAD    = 3'd1;
  localparam logic [2:0] OP_INC     = 3'd2;
  localparam logic [2:0] OP_DEC     = 3'd3;
  localparam logic [2:0] OP_FROM_SP = 3'd4;
  localparam logic [2:0] OP_TO_SP   = 3'd5;

  typedef enum logic [1:0] {
    SRC_LOAD = 2'd0,
    SRC_SP   = 2'd1,
    SRC_INC  = 2'd2,
    SRC_DEC  = 2'd3
  } src_sel_e;

  typedef struct packed {
    logic     regEn;
    logic     flagEn;
    logic     spWe;
    logic     narrow;
    logic     emu;
    src_sel_e srcSel;
  } idx_strobes_t;

endpackage

// File: rtl/idx_control.sv
module idx_control
  import idx_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic [2:0]   op,
  input  logic         widthSel,
  input  logic         emuMode,
  output idx_strobes_t st
);

  always_comb begin
    st        = '0;
    st.srcSel = SRC_LOAD;
    st.emu    = emuMode;
    st.narrow = widthSel | emuMode;
    case (op)
      OP_LOAD: begin
        st.regEn  = 1'b1;
        st.flagEn = 1'b1;
        st.srcSel = SRC_LOAD;
      end
      OP_INC: begin
        st.regEn  = 1'b1;
        st.flagEn = 1'b1;
        st.srcSel = SRC_INC;
      end
      OP_DEC: begin
        st.regEn  = 1'b1;
        st.flagEn = 1'b1;
        st.srcSel = SRC_DEC;
      end
      OP_FROM_SP: begin
        st.regEn  = 1'b1;
        st.flagEn = 1'b1;
        st.srcSel = SRC_SP;
      end
      OP_TO_SP: begin
        st.spWe = 1'b1;
      end
      default: ;
    endcase
  end

  // R6: a copy to the stack never also writes the register or the flags
  a_r6_copy_no_write: assert property (@(posedge clk) disable iff (!rstN)
    st.spWe |-> (!st.regEn && !st.flagEn));

  // R1: emulation mode always forces the narrow width
  a_r1_emu_narrow: assert property (@(posedge clk) disable iff (!rstN)
    emuMode |-> st.narrow);

endmodule

// File: rtl/idx_datapath.sv
module idx_datapath
  import idx_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 8,
  parameter int BANK_W   = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  idx_strobes_t             st,
  input  logic [DATA_W-1:0]        loadData,
  input  logic [DATA_W-1:0]        spIn,
  input  logic [BANK_W-1:0]        bank,
  input  logic [DATA_W-1:0]        base,
  output logic [DATA_W-1:0]        idxOut,
  output logic                     negFlag,
  output logic                     zeroFlag,
  output logic [DATA_W-1:0]        spOut,
  output logic [BANK_W+DATA_W-1:0] effAddr
);

  localparam int ADDR_W = BANK_W + DATA_W;
  localparam int HIGH_W = DATA_W - NARROW_W;
  localparam logic [HIGH_W-1:0] SP_PAGE = HIGH_W'(1);

  logic [DATA_W-1:0] idxQ;
  logic [DATA_W-1:0] widthMask;
  logic [DATA_W-1:0] nextVal;
  logic [DATA_W-1:0] result;
  logic              resultNeg;

  assign widthMask = st.narrow ? {{HIGH_W{1'b0}}, {NARROW_W{1'b1}}} : {DATA_W{1'b1}};

  always_comb begin
    case (st.srcSel)
      SRC_LOAD: nextVal = loadData;
      SRC_SP:   nextVal = spIn;
      SRC_INC:  nextVal = idxQ + DATA_W'(1);
      SRC_DEC:  nextVal = idxQ - DATA_W'(1);
      default:  nextVal = idxQ;
    endcase
  end

  assign result    = nextVal & widthMask;
  assign resultNeg = st.narrow ? result[NARROW_W-1] : result[DATA_W-1];

  // Register content is undefined until first written; only flags reset.
  always_ff @(posedge clk) begin
    if (st.regEn) idxQ <= result;
    else          idxQ <= idxQ & widthMask;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      negFlag  <= 1'b0;
      zeroFlag <= 1'b0;
    end else if (st.flagEn) begin
      negFlag  <= resultNeg;
      zeroFlag <= (result == '0);
    end
  end

  assign idxOut  = idxQ & widthMask;
  assign spOut   = st.emu ? {SP_PAGE, idxOut[NARROW_W-1:0]} : idxOut;
  assign effAddr = {bank, base} + {{BANK_W{1'b0}}, idxOut};

  // R3: a step up at unchanged width adds exactly one within that width
  a_r3_inc_step: assert property (@(posedge clk) disable iff (!rstN)
    ($past(st.regEn && st.srcSel == SRC_INC) && $past(st.narrow) == st.narrow)
      |-> idxOut == (($past(idxOut) + DATA_W'(1)) & widthMask));

  // R4: a step down at unchanged width subtracts exactly one within that width
  a_r4_dec_step: assert property (@(posedge clk) disable iff (!rstN)
    ($past(st.regEn && st.srcSel == SRC_DEC) && $past(st.narrow) == st.narrow)
      |-> idxOut == (($past(idxOut) - DATA_W'(1)) & widthMask));

  // R5: after a flag update at unchanged width, zero flag agrees with the register
  a_r5_zero_match: assert property (@(posedge clk) disable iff (!rstN)
    ($past(st.flagEn) && $past(st.narrow) == st.narrow)
      |-> zeroFlag == (idxOut == '0));

  // R6: a copy to the stack leaves both flags as they were
  a_r6_flags_kept: assert property (@(posedge clk) disable iff (!rstN)
    $past(st.spWe) |-> ($stable(negFlag) && $stable(zeroFlag)));

endmodule

// File: rtl/index_reg_unit.sv
module index_reg_unit
  import idx_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 8,
  parameter int BANK_W   = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [2:0]               op,
  input  logic [DATA_W-1:0]        loadData,
  input  logic                     widthSel,
  input  logic                     emuMode,
  input  logic [DATA_W-1:0]        spIn,
  input  logic [BANK_W-1:0]        bank,
  input  logic [DATA_W-1:0]        base,
  output logic [DATA_W-1:0]        idxOut,
  output logic                     negFlag,
  output logic                     zeroFlag,
  output logic                     spWe,
  output logic [DATA_W-1:0]        spOut,
  output logic [BANK_W+DATA_W-1:0] effAddr
);

  localparam int HIGH_W = DATA_W - NARROW_W;

  idx_strobes_t strobes;

  idx_control u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .op       (op),
    .widthSel (widthSel),
    .emuMode  (emuMode),
    .st       (strobes)
  );

  idx_datapath #(
    .DATA_W   (DATA_W),
    .NARROW_W (NARROW_W),
    .BANK_W   (BANK_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .st       (strobes),
    .loadData (loadData),
    .spIn     (spIn),
    .bank     (bank),
    .base     (base),
    .idxOut   (idxOut),
    .negFlag  (negFlag),
    .zeroFlag (zeroFlag),
    .spOut    (spOut),
    .effAddr  (effAddr)
  );

  assign spWe = strobes.spWe;

  // R6: in emulation mode the stack high part is the fixed page value 1
  a_r6_emu_page: assert property (@(posedge clk) disable iff (!rstN)
    (spWe && emuMode) |-> spOut[DATA_W-1:NARROW_W] == HIGH_W'(1));

  // R1: narrow width always presents a zero high part
  a_r1_high_zero: assert property (@(posedge clk) disable iff (!rstN)
    (widthSel || emuMode) |-> idxOut[DATA_W-1:NARROW_W] == '0);

endmodule

// File: tb/sim_index_reg_unit.sv
module sim_index_reg_unit;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic [2:0]  op;
  logic [15:0] loadData;
  logic        widthSel;
  logic        emuMode;
  logic [15:0] spIn;
  logic [7:0]  bank;
  logic [15:0] base;
  logic [15:0] idxOut;
  logic        negFlag;
  logic        zeroFlag;
  logic        spWe;
  logic [15:0] spOut;
  logic [23:0] effAddr;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  index_reg_unit u0 (
    .clk(clk), .rstN(rstN), .op(op), .loadData(loadData),
    .widthSel(widthSel), .emuMode(emuMode), .spIn(spIn),
    .bank(bank), .base(base), .idxOut(idxOut), .negFlag(negFlag),
    .zeroFlag(zeroFlag), .spWe(spWe), .spOut(spOut), .effAddr(effAddr)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one operation: drive after a falling edge, sample at the next falling edge
  task automatic doOp(input logic [2:0] o, input logic [15:0] d);
    @(negedge clk);
    op = o; loadData = d;
    @(negedge clk);
    op = 3'd0;
    #1;
  endtask

  task automatic checkState(input string req, input logic [15:0] eX, input bit eN, input bit eZ);
    check(idxOut == eX, req, idxOut, eX);
    check(negFlag == eN, {req, " N"}, negFlag, eN);
    check(zeroFlag == eZ, {req, " Z"}, zeroFlag, eZ);
  endtask

  task automatic tReset();
    rstN = 1'b0; op = 3'd0; loadData = '0; widthSel = 1'b0; emuMode = 1'b0;
    spIn = '0; bank = '0; base = '0;
    repeat (3) @(negedge clk);
    check(negFlag == 1'b0, "R5 reset N", negFlag, 0);
    check(zeroFlag == 1'b0, "R5 reset Z", zeroFlag, 0);
    check(spWe == 1'b0, "R6 reset spWe", spWe, 0);
    rstN = 1'b1;
  endtask

  task automatic tLoad();
    widthSel = 1'b0; emuMode = 1'b0;
    doOp(3'd1, 16'h8001); checkState("R2 load16", 16'h8001, 1, 0);
    widthSel = 1'b1;
    doOp(3'd1, 16'h12F0); checkState("R1 load8", 16'h00F0, 1, 0);
    widthSel = 1'b0; emuMode = 1'b1;
    doOp(3'd1, 16'hABCD); checkState("R1 emu load", 16'h00CD, 1, 0);
    emuMode = 1'b0;
    doOp(3'd1, 16'h0000); checkState("R5 load zero", 16'h0000, 0, 1);
  endtask

  task automatic tInc();
    widthSel = 1'b1;
    doOp(3'd1, 16'h00FF);
    doOp(3'd2, 16'h0000); checkState("R3 inc8 wrap", 16'h0000, 0, 1);
    widthSel = 1'b0;
    doOp(3'd1, 16'h00FF);
    doOp(3'd2, 16'h0000); checkState("R3 inc16 carry", 16'h0100, 0, 0);
    doOp(3'd1, 16'hFFFF);
    doOp(3'd2, 16'h0000); checkState("R3 inc16 wrap", 16'h0000, 0, 1);
    doOp(3'd1, 16'h7FFF);
    doOp(3'd2, 16'h0000); checkState("R5 inc16 neg", 16'h8000, 1, 0);
  endtask

  task automatic tDec();
    widthSel = 1'b1;
    doOp(3'd1, 16'h0000);
    doOp(3'd3, 16'h0000); checkState("R4 dec8 wrap", 16'h00FF, 1, 0);
    widthSel = 1'b0;
    doOp(3'd1, 16'h0000);
    doOp(3'd3, 16'h0000); checkState("R4 dec16 wrap", 16'hFFFF, 1, 0);
    doOp(3'd1, 16'h0100);
    doOp(3'd3, 16'h0000); checkState("R4 dec16 borrow", 16'h00FF, 0, 0);
  endtask

  task automatic tToSp();
    widthSel = 1'b0; emuMode = 1'b0;
    doOp(3'd1, 16'h1234);
    @(negedge clk);
    op = 3'd5; #1;
    check(spWe == 1'b1, "R6 spWe", spWe, 1);
    check(spOut == 16'h1234, "R6 spOut native", spOut, 16'h1234);
    @(negedge clk); op = 3'd0; #1;
    checkState("R6 copy keeps", 16'h1234, 0, 0);
    check(spWe == 1'b0, "R6 spWe drop", spWe, 0);
    emuMode = 1'b1;
    doOp(3'd1, 16'h00FE);
    @(negedge clk);
    op = 3'd5; #1;
    check(spOut == 16'h01FE, "R6 spOut emu", spOut, 16'h01FE);
    @(negedge clk); op = 3'd0; #1;
    checkState("R6 emu keeps", 16'h00FE, 1, 0);
    emuMode = 1'b0;
  endtask

  task automatic tFromSp();
    widthSel = 1'b0; spIn = 16'h80FF;
    doOp(3'd4, 16'h0000); checkState("R7 fill16", 16'h80FF, 1, 0);
    widthSel = 1'b1; spIn = 16'h5500;
    doOp(3'd4, 16'h0000); checkState("R7 fill8 zero", 16'h0000, 0, 1);
    widthSel = 1'b0;
  endtask

  task automatic tAddr();
    widthSel = 1'b0;
    doOp(3'd1, 16'h0020);
    bank = 8'h12; base = 16'hFFF0; #1;
    check(effAddr == 24'h130010, "R8 bank carry", effAddr, 24'h130010);
    doOp(3'd1, 16'h0001);
    bank = 8'hFF; base = 16'hFFFF; #1;
    check(effAddr == 24'h000000, "R8 full wrap", effAddr, 24'h000000);
    widthSel = 1'b1;
    doOp(3'd1, 16'h0080);
    bank = 8'h12; base = 16'h0000; #1;
    check(effAddr == 24'h120080, "R8 zero extend", effAddr, 24'h120080);
    widthSel = 1'b0;
  endtask

  task automatic tNop();
    widthSel = 1'b0;
    doOp(3'd1, 16'hC3A5);
    doOp(3'd0, 16'h1111); checkState("R9 op0", 16'hC3A5, 1, 0);
    doOp(3'd6, 16'h2222); checkState("R9 op6", 16'hC3A5, 1, 0);
    doOp(3'd7, 16'h0000); checkState("R9 op7", 16'hC3A5, 1, 0);
  endtask

  task automatic tNarrowClear();
    widthSel = 1'b0;
    doOp(3'd1, 16'hBEEF);
    widthSel = 1'b1;
    doOp(3'd0, 16'h0000);
    widthSel = 1'b0; #1;
    check(idxOut == 16'h00EF, "R10 high cleared", idxOut, 16'h00EF);
  endtask

  initial begin
    tReset();
    tLoad();
    tInc();
    tDec();
    tToSp();
    tFromSp();
    tAddr();
    tNop();
    tNarrowClear();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule